// File: doc/BRIEF.md
# Timing-Error Detecting Pipeline with Replay

This block is a short in-order pipeline whose stage registers can catch their own late captures. Operations enter through a valid/ready stream and are held in a small replay store until they retire. Each operation passes through a chain of stage registers, and each stage applies a fixed mixing step (rotate left by one, then XOR with a stage key). The result leaves through a valid/ready retire stream. A protected stage register holds a main copy and a shadow copy. The shadow samples the same input later, so it always receives the settled value. A fault input lets the environment model a capture that arrived too late: the main copy takes a corrupted word while the shadow keeps the settled one.

When a protected register sees its main and shadow copies differ, the block spends one recovery cycle. In that cycle every mismatching register reloads its shadow value, and every stage younger (closer to the input) than the youngest erring stage is emptied. The replay store rewinds its issue point to the operation just after the one held in that stage. Nothing retires while recovery is in progress, so every accepted operation leaves exactly once, in order, with its fault-free value.

Stream rules. An input word is taken on a rising edge where `in_valid` and `in_ready` are both high. An output word is taken when `ret_valid` and `ret_ready` are both high. While `ret_valid` is high and `ret_ready` is low, the whole pipeline stalls and `ret_data` holds its value.

Top module: `late_catch_pipe`

## Requirements
- R1: `in_ready` is high exactly when fewer than DEPTH (default 8) accepted operations are still unretired. The block never holds more than DEPTH.
- R2: `ret_data` for an operation x is the result of applying the step for stages 0..NSTG-1 in turn. The step for stage s is `rotl1(x) ^ ((KEY*(s+1)) mod 2^W)`, with W=16, NSTG=4 and KEY=16'h1D2B by default.
- R3: Suppose a protected stage captures a valid operation while its `late_hit` bit is high. In the following cycle that stage's `stg_data` equals the correct value XOR `late_mask`, and its `stg_err` bit is high.
- R4: `recover` is high in exactly the cycles where some `stg_err` bit is high. In the next cycle each erring register holds its corrected value and `recover` is low.
- R5: On recovery, every stage with a lower index than the youngest erring stage shows `stg_valid` low in the next cycle. Stages from the erring one onward keep their operations.
- R6: Every accepted operation retires exactly once, in acceptance order, with its R2 value, whatever faults are injected.
- R7: `ret_valid` is low in any cycle where `recover` is high.
- R8: While `ret_valid` is high and `ret_ready` is low, `ret_valid` stays high and `ret_data` is unchanged in the next cycle.
- R9: A stage whose bit in PROT_MASK is 0 (stage 2 by default) ignores its `late_hit` bit. Its `stg_err` bit stays low and its output is unaffected.
- R10: After reset, all `stg_valid` and `stg_err` bits are low, `recover` and `ret_valid` are low, and `in_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input operation offered |
| in_ready | output | 1 | Replay store has room |
| in_data | input | W | Input operation word |
| ret_valid | output | 1 | Retiring result available |
| ret_ready | input | 1 | Consumer takes the result |
| ret_data | output | W | Retiring result |
| late_hit | input | NSTG | Per-stage late-capture fault model |
| late_mask | input | W | Bits corrupted by a late capture |
| stg_valid | output | NSTG | Per-stage register occupancy |
| stg_data | output | NSTG*W | Per-stage register contents, stage s at bits s*W |
| stg_err | output | NSTG | Per-stage main/shadow mismatch |
| recover | output | 1 | Recovery cycle: restore, flush and rewind |

## Verification
The in-RTL assertions check the following on every cycle:
- a restored register no longer mismatches and a flushed one is empty;
- recovery never lasts two cycles in a row;
- a stalled result holds;
- the replay store's pointers stay ordered and within its depth.

Some behaviours only the bench scenarios can show:
- the exact corrupted and corrected values around a fault;
- which stages a recovery empties;
- that an unprotected stage ignores its fault input;
- that the retired stream under random faults and back-pressure matches the fault-free sequence.

// File: rtl/lc_pkg.sv
`timescale 1ns/1ps
package lc_pkg;
  // One pipeline step on a w-bit word (w < 64): rotate left by one, then
  // XOR with the stage key multiple.
  function automatic logic [63:0] lc_mix(input logic [63:0] x, input int unsigned w,
                                         input logic [63:0] key, input int unsigned s);
    logic [63:0] m;
    logic [63:0] r;
    m = (64'd1 << w) - 64'd1;
    r = ((x << 1) | (x >> (w - 1))) & m;
    return r ^ ((key * 64'(s + 1)) & m);
  endfunction
endpackage

// File: rtl/lc_replay_buf.sv
`timescale 1ns/1ps
module lc_replay_buf #(
  parameter int W     = 16,
  parameter int DEPTH = 8,
  localparam int PW   = $clog2(DEPTH),
  localparam int TW   = PW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [W-1:0]  push_data,
  output logic          has_room,
  input  logic          take,
  input  logic          rewind,
  input  logic [TW-1:0] rewind_ptr,
  input  logic          retire,
  output logic          issue_valid,
  output logic [W-1:0]  issue_data,
  output logic [TW-1:0] issue_tag
);
  logic [W-1:0]  mem [DEPTH];
  logic [TW-1:0] head, tail, issue;

  assign has_room    = (tail - head) != TW'(DEPTH);
  assign issue_valid = issue != tail;
  assign issue_data  = mem[issue[PW-1:0]];
  assign issue_tag   = issue;

  always_ff @(posedge clk) begin
    if (push) mem[tail[PW-1:0]] <= push_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      head  <= '0;
      tail  <= '0;
      issue <= '0;
    end else begin
      if (push)   tail <= tail + 1'b1;
      if (retire) head <= head + 1'b1;
      if (rewind)    issue <= rewind_ptr;
      else if (take) issue <= issue + 1'b1;
    end
  end

  a_r1_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    (tail - head) <= TW'(DEPTH));
  a_r6_issue_window: assert property (@(posedge clk) disable iff (!rst_n)
    (issue - head) <= (tail - head));
endmodule

// File: rtl/lc_guard_reg.sv
`timescale 1ns/1ps
module lc_guard_reg #(
  parameter int W       = 16,
  parameter int TW      = 4,
  parameter bit PROTECT = 1'b1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cap,
  input  logic          restore,
  input  logic          flush,
  input  logic          late,
  input  logic [W-1:0]  late_mask,
  input  logic          d_valid,
  input  logic [W-1:0]  d_data,
  input  logic [TW-1:0] d_tag,
  output logic          q_valid,
  output logic [W-1:0]  q_data,
  output logic [TW-1:0] q_tag,
  output logic          err
);
  logic [W-1:0] fix;
  logic [W-1:0] inj;

  generate
    if (PROTECT) begin : g_shadow
      logic [W-1:0] shadow;
      always_ff @(posedge clk) begin
        if (!rst_n) shadow <= '0;
        else if (cap && !flush && !restore) shadow <= d_data;
      end
      assign fix = shadow;
      assign inj = late ? late_mask : '0;
      assign err = q_valid && (q_data != shadow);
    end else begin : g_plain
      logic unused_late;
      assign unused_late = late ^ (^late_mask) ^ restore;
      assign fix = q_data;
      assign inj = '0;
      assign err = 1'b0;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      q_valid <= 1'b0;
      q_data  <= '0;
      q_tag   <= '0;
    end else if (flush) begin
      q_valid <= 1'b0;
    end else if (restore) begin
      q_data <= fix;
    end else if (cap) begin
      q_valid <= d_valid;
      q_data  <= d_data ^ inj;
      q_tag   <= d_tag;
    end
  end

  a_r4_restore_clears: assert property (@(posedge clk) disable iff (!rst_n)
    restore |=> !err);
  a_r5_flush_empties: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> !q_valid);
endmodule

// File: rtl/lc_recover_ctl.sv
`timescale 1ns/1ps
module lc_recover_ctl #(
  parameter int NSTG = 4
) (
  input  logic [NSTG-1:0] err,
  output logic            recover,
  output logic [NSTG-1:0] flush,
  output logic [NSTG-1:0] restore,
  output logic [NSTG-1:0] youngest
);
  assign recover = |err;
  assign restore = err;

  always_comb begin
    logic seen;
    seen = 1'b0;
    for (int s = 0; s < NSTG; s++) begin
      youngest[s] = err[s] && !seen;
      seen        = seen || err[s];
      flush[s]    = recover && !seen;
    end
  end
endmodule

// File: rtl/late_catch_pipe.sv
`timescale 1ns/1ps
module late_catch_pipe #(
  parameter int              W         = 16,
  parameter int              NSTG      = 4,
  parameter int              DEPTH     = 8,
  parameter logic [W-1:0]    KEY       = 16'h1D2B,
  parameter logic [NSTG-1:0] PROT_MASK = 4'b1011,
  localparam int             PW        = $clog2(DEPTH),
  localparam int             TW        = PW + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [W-1:0]      in_data,
  output logic              ret_valid,
  input  logic              ret_ready,
  output logic [W-1:0]      ret_data,
  input  logic [NSTG-1:0]   late_hit,
  input  logic [W-1:0]      late_mask,
  output logic [NSTG-1:0]   stg_valid,
  output logic [NSTG*W-1:0] stg_data,
  output logic [NSTG-1:0]   stg_err,
  output logic              recover
);
  import lc_pkg::*;

  logic [W-1:0]    sq   [NSTG];
  logic [TW-1:0]   stag [NSTG];
  logic [NSTG-1:0] flush, restore, youngest;
  logic            move, retire, iss_v;
  logic [W-1:0]    iss_d;
  logic [TW-1:0]   iss_t, sel_tag;

  assign move      = !recover && (!stg_valid[NSTG-1] || ret_ready);
  assign ret_valid = stg_valid[NSTG-1] && !recover;
  assign ret_data  = sq[NSTG-1];
  assign retire    = ret_valid && ret_ready;

  lc_replay_buf #(.W(W), .DEPTH(DEPTH)) u_buf (
    .clk(clk), .rst_n(rst_n),
    .push(in_valid && in_ready), .push_data(in_data), .has_room(in_ready),
    .take(move && iss_v), .rewind(recover), .rewind_ptr(sel_tag + 1'b1),
    .retire(retire),
    .issue_valid(iss_v), .issue_data(iss_d), .issue_tag(iss_t)
  );

  lc_recover_ctl #(.NSTG(NSTG)) u_ctl (
    .err(stg_err), .recover(recover), .flush(flush),
    .restore(restore), .youngest(youngest)
  );

  always_comb begin
    sel_tag = '0;
    for (int s = 0; s < NSTG; s++)
      if (youngest[s]) sel_tag = sel_tag | stag[s];
  end

  generate
    for (genvar s = 0; s < NSTG; s++) begin : g_stg
      logic          dv;
      logic [W-1:0]  src;
      logic [W-1:0]  dd;
      logic [TW-1:0] dt;
      if (s == 0) begin : g_head
        assign dv  = iss_v;
        assign src = iss_d;
        assign dt  = iss_t;
      end else begin : g_body
        assign dv  = stg_valid[s-1];
        assign src = sq[s-1];
        assign dt  = stag[s-1];
      end
      assign dd = W'(lc_mix(64'(src), W, 64'(KEY), s));

      lc_guard_reg #(.W(W), .TW(TW), .PROTECT(PROT_MASK[s])) u_reg (
        .clk(clk), .rst_n(rst_n),
        .cap(move), .restore(restore[s]), .flush(flush[s]),
        .late(late_hit[s]), .late_mask(late_mask),
        .d_valid(dv), .d_data(dd), .d_tag(dt),
        .q_valid(stg_valid[s]), .q_data(sq[s]), .q_tag(stag[s]),
        .err(stg_err[s])
      );
      assign stg_data[s*W +: W] = sq[s];
    end
  endgenerate

  a_r4_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    recover |=> !recover);
  a_r8_hold_under_stall: assert property (@(posedge clk) disable iff (!rst_n)
    (ret_valid && !ret_ready) |=> (ret_valid && $stable(ret_data)));
endmodule

// File: tb/late_catch_pipe_test.sv
`timescale 1ns/1ps
module late_catch_pipe_test;
  localparam logic [15:0] KEY = 16'h1D2B;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [15:0] in_data = '0;
  logic        ret_valid;
  logic        ret_ready = 1'b0;
  logic [15:0] ret_data;
  logic [3:0]  late_hit = '0;
  logic [15:0] late_mask = '0;
  logic [3:0]  stg_valid;
  logic [63:0] stg_data;
  logic [3:0]  stg_err;
  logic        recover;

  int nchk = 0, nfail = 0;
  logic [15:0] expq [4096];
  int wr = 0, rd = 0;
  int err_cnt [4];
  int rec_cnt = 0;

  always #2 clk = ~clk;

  late_catch_pipe uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .ret_valid(ret_valid), .ret_ready(ret_ready),
    .ret_data(ret_data), .late_hit(late_hit), .late_mask(late_mask),
    .stg_valid(stg_valid), .stg_data(stg_data), .stg_err(stg_err),
    .recover(recover)
  );

  function automatic logic [15:0] step(input logic [15:0] x, input int s);
    return {x[14:0], x[15]} ^ 16'(KEY * (s + 1));
  endfunction

  function automatic logic [15:0] upto(input logic [15:0] x, input int n);
    logic [15:0] v;
    v = x;
    for (int s = 0; s < n; s++) v = step(v, s);
    return v;
  endfunction

  task automatic chk(input bit ok, input string what, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", what, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  // Monitor: sampled mid-cycle, inputs change just after the rising edge.
  initial begin
    for (int i = 0; i < 4; i++) err_cnt[i] = 0;
    forever begin
      @(negedge clk);
      if (rst_n) begin
        if (in_valid && in_ready) begin
          expq[wr % 4096] = in_data;
          wr++;
        end
        for (int s = 0; s < 4; s++) if (stg_err[s]) err_cnt[s]++;
        if (recover) begin
          rec_cnt++;
          chk(!ret_valid, "R7 no retire during recovery", 32'(ret_valid), 32'd0);
        end
        chk(recover == (|stg_err), "R4 recover tracks errors", 32'(recover), 32'(|stg_err));
        if (ret_valid && ret_ready) begin
          if (rd < wr)
            chk(ret_data == upto(expq[rd % 4096], 4), "R2/R6 retired value", 32'(ret_data),
                32'(upto(expq[rd % 4096], 4)));
          else
            chk(1'b0, "R6 retire without pending op", 32'(rd), 32'(wr));
          rd++;
        end
      end
    end
  end

  task automatic drain();
    in_valid  = 1'b0;
    ret_ready = 1'b1;
    late_hit  = '0;
    for (int i = 0; i < 300; i++) begin
      if (rd == wr && stg_valid == 4'b0) break;
      tick();
    end
    @(negedge clk);
    chk(rd == wr && stg_valid == 4'b0, "R6 drained", 32'(rd), 32'(wr));
    tick();
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(in_ready == 1'b1, "R10 in_ready after reset", 32'(in_ready), 32'd1);
    chk(ret_valid == 1'b0, "R10 ret_valid after reset", 32'(ret_valid), 32'd0);
    chk(stg_valid == 4'b0, "R10 stages empty", 32'(stg_valid), 32'd0);
    chk(stg_err == 4'b0 && !recover, "R10 no error", 32'({stg_err, recover}), 32'd0);
    tick();
    rst_n = 1'b1;
    tick();

    // R1 and R8: fill under back-pressure.
    begin
      int w0;
      w0 = wr;
      ret_ready = 1'b0;
      for (int i = 0; i < 12; i++) begin
        in_valid = 1'b1;
        in_data  = 16'h0A00 + 16'(i);
        tick();
      end
      in_valid = 1'b0;
      @(negedge clk);
      chk(wr - w0 == 8, "R1 accepted up to depth", 32'(wr - w0), 32'd8);
      chk(in_ready == 1'b0, "R1 in_ready low when full", 32'(in_ready), 32'd0);
      chk(ret_valid == 1'b1, "R8 result waiting", 32'(ret_valid), 32'd1);
      for (int i = 0; i < 4; i++) begin
        @(negedge clk);
        chk(ret_valid && ret_data == upto(16'h0A00, 4), "R8 stalled result held",
            32'(ret_data), 32'(upto(16'h0A00, 4)));
      end
      tick();
      drain();
    end

    // R3, R4, R5: fault on protected stage 1 with a younger op behind it.
    begin
      int e0;
      bit seen, prev;
      e0 = err_cnt[1];
      seen = 1'b0;
      prev = 1'b0;
      ret_ready = 1'b1;
      late_hit  = 4'b0010;
      late_mask = 16'h00F0;
      in_valid  = 1'b1;
      in_data   = 16'h1234;
      tick();
      in_data = 16'hBEEF;
      tick();
      in_valid = 1'b0;
      for (int i = 0; i < 40; i++) begin
        @(negedge clk);
        if (prev) begin
          chk(!stg_valid[0], "R5 younger stage flushed", 32'(stg_valid), 32'd2);
          chk(stg_valid[1] && stg_data[31:16] == upto(16'h1234, 2), "R4 register restored",
              32'(stg_data[31:16]), 32'(upto(16'h1234, 2)));
          chk(!recover, "R4 recovery lasts one cycle", 32'(recover), 32'd0);
          prev = 1'b0;
        end
        if (stg_err[1] && !seen) begin
          seen = 1'b1;
          prev = 1'b1;
          chk(stg_data[31:16] == (upto(16'h1234, 2) ^ 16'h00F0), "R3 corrupted capture",
              32'(stg_data[31:16]), 32'(upto(16'h1234, 2) ^ 16'h00F0));
          chk(stg_valid[0] && recover, "R3 error raises recovery", 32'({stg_valid[0], recover}), 32'd3);
        end
        @(posedge clk);
      end
      chk(seen, "R3 error flagged", 32'(seen), 32'd1);
      chk(err_cnt[1] - e0 == 2, "R3 one error per faulted op", 32'(err_cnt[1] - e0), 32'd2);
      drain();
    end

    // R9: fault input on unprotected stage 2 has no effect.
    begin
      int r0, e2;
      r0 = rec_cnt;
      e2 = err_cnt[2];
      late_hit  = 4'b0100;
      late_mask = 16'hFFFF;
      for (int i = 0; i < 6; i++) begin
        in_valid = 1'b1;
        in_data  = 16'h5000 + 16'(i * 7);
        tick();
      end
      in_valid = 1'b0;
      repeat (20) tick();
      chk(err_cnt[2] == e2 && rec_cnt == r0, "R9 unprotected stage ignores fault",
          32'(rec_cnt - r0), 32'd0);
      drain();
    end

    // R6: random traffic, faults and back-pressure.
    begin
      int pushed, r0;
      pushed = 0;
      r0 = rec_cnt;
      for (int c = 0; c < 20000 && pushed < 400; c++) begin
        if (in_valid && in_ready) pushed++;
        if (!(in_valid && !in_ready)) begin
          in_valid = (($urandom % 10) < 7) && (pushed < 400);
          in_data  = 16'($urandom);
        end
        ret_ready = ($urandom % 4) != 0;
        for (int s = 0; s < 4; s++) late_hit[s] = ($urandom % 10) == 0;
        late_mask = 16'($urandom) | 16'h0001;
        @(negedge clk);
        @(posedge clk);
        #1;
      end
      drain();
      chk(rec_cnt > r0, "R6 recoveries exercised", 32'(rec_cnt - r0), 32'd1);
      chk(rd == wr, "R6 all ops retired once", 32'(rd), 32'(wr));
    end

    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    nchk++;
    nfail++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", rd, wr);
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule